// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag Unit

This block collects the three interrupt causes of a real-time clock into one status byte and one interrupt request pin. The three causes are the periodic tick, the alarm match and the end of a time update. Each cause has a sticky flag that latches an incoming one-cycle pulse and holds it until software reads the status byte. The alarm cause is produced inside the block. On each update strobe, a comparator checks the current seconds, minutes and hours against the three alarm values.

A summary bit at the top of the status byte is set when any latched flag has its enable set. The active-low interrupt pin follows that summary bit. Reading the status byte clears every flag in the clock cycle of the read. A cause that fires in that same cycle is kept, so no event is lost. The time counters that produce the tick and update strobes, and the time values, are outside this block.

All pins are plain control and status signals. There is no streamed data path, so no valid/ready handshake is used. The read strobe is a single-cycle pulse and cannot be stalled.

Top module: `rtc_irq_flags`

## Requirements
- R1: After reset, `stat_c` reads 0x00 and `irq_n` is 1.
- R2: A one-cycle pulse on `per_evt` sets status bit 6. The bit stays set until a read clears it.
- R3: A one-cycle pulse on `upd_evt` sets status bit 4. The bit stays set until a read clears it.
- R4: When `upd_evt` is high and seconds, minutes and hours all equal their alarm values in that cycle, status bit 5 is set on the next clock edge and stays set until a read clears it.
- R5: Status bit 5 is not set if any one of the three fields differs from its alarm value. It is also not set, whatever the values, in a cycle without `upd_evt`.
- R6: The flags in bits 6, 5 and 4 are set whatever the value of `ien`.
- R7: Status bit 7 is 1 exactly when at least one source flag is set together with its enable. The enables are `ien[2]` for the periodic flag (bit 6), `ien[1]` for the alarm flag (bit 5) and `ien[0]` for the update flag (bit 4).
- R8: `irq_n` equals the inverse of status bit 7 in every cycle.
- R9: A cycle with `stat_rd` high returns the current flags on `stat_c` and clears bits 6:4 at the next edge. Bit 7 follows, because it is derived from those flags.
- R10: A source event in the same cycle as `stat_rd` wins over the clear: its flag is set after the edge.
- R11: Status bits 3:0 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| per_evt | input | 1 | Periodic tick pulse |
| upd_evt | input | 1 | Update-ended strobe; also triggers the alarm compare |
| ien | input | 3 | Enables: [2] periodic, [1] alarm, [0] update |
| now_sec | input | 8 | Current seconds |
| now_min | input | 8 | Current minutes |
| now_hr | input | 8 | Current hours |
| alm_sec | input | 8 | Alarm seconds |
| alm_min | input | 8 | Alarm minutes |
| alm_hr | input | 8 | Alarm hours |
| stat_rd | input | 1 | Status read strobe; clears the flags |
| stat_c | output | 8 | Status byte: [7] summary, [6] periodic, [5] alarm, [4] update, [3:0] zero |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions check on every cycle that:
- the low nibble stays zero;
- the interrupt pin mirrors the summary bit;
- the summary bit agrees with the latched flags and their enables;
- a flag holds when no read occurs;
- a read with no competing event leaves the flags clear;
- a tick that collides with a read survives.

Only the bench scenarios show that the alarm compare needs all three fields to match, and that it needs the update strobe. They also show that flags latch while their enables are off, and that a flag which was masked raises the interrupt as soon as its enable is turned on.

// File: rtl/rtc_irq_pkg.sv
`timescale 1ns/1ps
package rtc_irq_pkg;
  localparam int NSRC     = 3;
  localparam int FLAG_LSB = 4;
  localparam int SUM_BIT  = 7;
  // Source index i maps to status bit FLAG_LSB+i
  typedef enum logic [1:0] {
    SRC_UPD = 2'd0,
    SRC_ALM = 2'd1,
    SRC_PER = 2'd2
  } src_e;
endpackage

// File: rtl/rtc_alarm_cmp.sv
`timescale 1ns/1ps
module rtc_alarm_cmp #(
  parameter int W      = 8,
  parameter int FIELDS = 3
) (
  input  logic                  upd_stb,
  input  logic [FIELDS*W-1:0]   now_v,
  input  logic [FIELDS*W-1:0]   alm_v,
  output logic                  hit
);
  logic [FIELDS-1:0] eq;
  for (genvar g = 0; g < FIELDS; g++) begin : g_fld
    assign eq[g] = (now_v[g*W +: W] == alm_v[g*W +: W]);
  end
  assign hit = upd_stb & (&eq);
endmodule

// File: rtl/rtc_flag_cell.sv
`timescale 1ns/1ps
module rtc_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/rtc_irq_summary.sv
`timescale 1ns/1ps
module rtc_irq_summary #(
  parameter int NSRC = 3
) (
  input  logic [NSRC-1:0] flags,
  input  logic [NSRC-1:0] en,
  output logic            sum,
  output logic            req_n
);
  always_comb begin
    sum   = |(flags & en);
    req_n = ~sum;
  end
endmodule

// File: rtl/rtc_irq_flags.sv
`timescale 1ns/1ps
module rtc_irq_flags
  import rtc_irq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         per_evt,
  input  logic         upd_evt,
  input  logic [2:0]   ien,
  input  logic [W-1:0] now_sec,
  input  logic [W-1:0] now_min,
  input  logic [W-1:0] now_hr,
  input  logic [W-1:0] alm_sec,
  input  logic [W-1:0] alm_min,
  input  logic [W-1:0] alm_hr,
  input  logic         stat_rd,
  output logic [7:0]   stat_c,
  output logic         irq_n
);
  logic            alm_hit;
  logic [NSRC-1:0] set_v;
  logic [NSRC-1:0] flags;
  logic            sum;

  rtc_alarm_cmp #(.W(W), .FIELDS(3)) u_cmp (
    .upd_stb (upd_evt),
    .now_v   ({now_hr, now_min, now_sec}),
    .alm_v   ({alm_hr, alm_min, alm_sec}),
    .hit     (alm_hit)
  );

  always_comb begin
    set_v          = '0;
    set_v[SRC_UPD] = upd_evt;
    set_v[SRC_ALM] = alm_hit;
    set_v[SRC_PER] = per_evt;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    rtc_flag_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_v[i]),
      .clr_i  (stat_rd),
      .flag_o (flags[i])
    );
  end

  rtc_irq_summary #(.NSRC(NSRC)) u_sum (
    .flags (flags),
    .en    (ien),
    .sum   (sum),
    .req_n (irq_n)
  );

  always_comb begin
    stat_c                               = '0;
    stat_c[SUM_BIT]                      = sum;
    stat_c[FLAG_LSB +: NSRC]             = flags;
  end
endmodule

// File: rtl/rtc_irq_flags_chk.sv
`timescale 1ns/1ps
module rtc_irq_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       per_evt,
  input logic       upd_evt,
  input logic [2:0] ien,
  input logic       stat_rd,
  input logic [7:0] stat_c,
  input logic       irq_n
);
  p_low_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stat_c[3:0] == 4'h0);
  p_pin_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == !stat_c[7]);
  p_summary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_c[7] == |(stat_c[6:4] & ien));
  p_per_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_c[6] && !stat_rd) |=> stat_c[6]);
  p_upd_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_c[4] && !stat_rd) |=> stat_c[4]);
  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !per_evt && !upd_evt) |=> (stat_c[6:4] == 3'b000));
  p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && per_evt) |=> stat_c[6]);
endmodule

bind rtc_irq_flags rtc_irq_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .per_evt(per_evt), .upd_evt(upd_evt),
  .ien(ien), .stat_rd(stat_rd), .stat_c(stat_c), .irq_n(irq_n)
);

// File: tb/sim_rtc_irq_flags.sv
`timescale 1ns/1ps
module sim_rtc_irq_flags;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       per_evt = 1'b0, upd_evt = 1'b0, stat_rd = 1'b0;
  logic [2:0] ien = 3'b000;
  logic [7:0] now_sec = 0, now_min = 0, now_hr = 0;
  logic [7:0] alm_sec = 0, alm_min = 0, alm_hr = 0;
  logic [7:0] stat_c;
  logic       irq_n;

  int tests = 0, fails = 0, cyc = 0;
  logic [2:0] mflags = 3'b000;  // [2] periodic, [1] alarm, [0] update

  always #10 clk = ~clk;  // 50 MHz

  rtc_irq_flags u0 (
    .clk(clk), .rst_n(rst_n), .per_evt(per_evt), .upd_evt(upd_evt),
    .ien(ien), .now_sec(now_sec), .now_min(now_min), .now_hr(now_hr),
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
    .stat_rd(stat_rd), .stat_c(stat_c), .irq_n(irq_n)
  );

  function automatic logic [7:0] exp_stat(logic [2:0] f, logic [2:0] e);
    return {|(f & e), f, 4'h0};
  endfunction

  function automatic logic [2:0] exp_next(logic [2:0] f, logic p, logic u,
                                          logic rd, logic match);
    logic [2:0] s = {p, u & match, u};
    return rd ? s : (f | s);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic check_now(string req);
    chk(req, stat_c, exp_stat(mflags, ien));
    chk("R8", {7'd0, irq_n}, {7'd0, ~|(mflags & ien)});
  endtask

  // Drive one cycle of stimulus; outputs are checked before the edge.
  task automatic step(logic p, logic u, logic rd, string req);
    logic m;
    per_evt = p; upd_evt = u; stat_rd = rd;
    #1;
    check_now(req);
    m = (now_sec == alm_sec) && (now_min == alm_min) && (now_hr == alm_hr);
    @(posedge clk);
    mflags = exp_next(mflags, p, u, rd, m);
    @(negedge clk);
    per_evt = 0; upd_evt = 0; stat_rd = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset", stat_c, 8'h00);
    chk("R1 irq", {7'd0, irq_n}, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R6: periodic with enables off, then sticky
    ien = 3'b000;
    step(1, 0, 0, "R2");
    step(0, 0, 0, "R2 sticky");
    chk("R6 per flag w/o enable", stat_c, 8'h40);
    ien = 3'b100; #1;
    chk("R7 enable raises summary", stat_c, 8'hC0);
    chk("R8 irq low", {7'd0, irq_n}, 8'h00);
    step(0, 0, 1, "R9 read returns flags");
    chk("R9 cleared", stat_c, 8'h00);

    // R3 / R4: update with matching alarm
    now_sec = 8'h30; now_min = 8'h15; now_hr = 8'h07;
    alm_sec = 8'h30; alm_min = 8'h15; alm_hr = 8'h07;
    ien = 3'b010;
    step(0, 1, 0, "R4");
    chk("R4 alarm+update set", stat_c, 8'hB0);
    step(0, 0, 1, "R9");

    // R5: one field mismatch each, and no strobe
    for (int k = 0; k < 3; k++) begin
      alm_sec = (k == 0) ? 8'h31 : 8'h30;
      alm_min = (k == 1) ? 8'h16 : 8'h15;
      alm_hr  = (k == 2) ? 8'h08 : 8'h07;
      step(0, 1, 0, "R5");
      chk("R5 mismatch no alarm", stat_c & 8'h20, 8'h00);
      chk("R3 update flag", stat_c & 8'h10, 8'h10);
      step(0, 0, 1, "R9");
    end
    alm_sec = 8'h30; alm_min = 8'h15; alm_hr = 8'h07;
    step(0, 0, 0, "R5 no strobe");
    chk("R5 match without strobe", stat_c, 8'h00);

    // R10: event colliding with read
    step(1, 0, 0, "R2");
    step(1, 0, 1, "R10");
    chk("R10 event wins", stat_c & 8'h40, 8'h40);
    step(0, 1, 1, "R10");
    chk("R10 update wins", stat_c & 8'h70, 8'h30);
    step(0, 0, 1, "R9");

    // Constrained random mix, time fields in a small range to get matches
    for (int i = 0; i < 3000; i++) begin
      ien     = 3'($urandom_range(0, 7));
      now_sec = 8'($urandom_range(0, 1)); alm_sec = 8'($urandom_range(0, 1));
      now_min = 8'($urandom_range(0, 1)); alm_min = 8'($urandom_range(0, 1));
      now_hr  = 8'($urandom_range(0, 1)); alm_hr  = 8'($urandom_range(0, 1));
      step(($urandom_range(0, 9) < 2), ($urandom_range(0, 9) < 2),
           ($urandom_range(0, 9) < 2), "R7 R11 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule